// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

This block decides which of ten vector slots may interrupt the CPU, and it gives the CPU that slot's entry address. Each slot gathers two request sources through a logical OR. Each slot also has a one-bit level select. That bit lifts the slot from the low level to the highest level the slot is allowed to use. Only the two lowest slots may reach the top level; every other slot can reach the middle level at most.

The block records which levels are in service as a mask of three bits, one bit per level. An acknowledge from the CPU adds the winner's level to the mask. A return strobe removes the highest level in the mask. A slot can interrupt only when its level is strictly above every level in service. The CPU request output and the address are registered, and both are recomputed on every clock. Arbitration already takes into account an acknowledge or return given in the same cycle. The block never clears a request, so software must clear the sources itself.

Top module: `prio_vec_arb`

## Requirements
- R1: While `irq` is high, `vec_addr` equals 0x03 + 8*v for the winning slot v (slot 0 gives 0x03, slot 9 gives 0x4B). While `irq` is low, `vec_addr` is 0x00. Both outputs are 0 after reset.
- R2: Slot v requests when `src[2v]` or `src[2v+1]` is high.
- R3: When `lvl_sel[v]` is 0, slot v is at the low level. When it is 1, slots 0 and 1 move to the top level and slots 2 to 9 move to the middle level.
- R4: Among the requesting slots, the one with the highest level wins (top above middle above low).
- R5: When several requesting slots share the highest level, the slot with the lowest index (lowest address) wins.
- R6: `irq` and `vec_addr` follow a change of the inputs at the first rising clock edge after the change, not before.
- R7: When `ack` is high while `irq` is high, the winner's level enters the in-service mask. From the next cycle on, requests at or below the highest in-service level do not raise `irq`, and a strictly higher level does raise it.
- R8: A `reti` pulse removes the highest in-service level. A request that was held back then raises `irq` at that same edge.
- R9: An acknowledge does not clear a request. After the matching `reti`, a source that is still high raises `irq` again.
- R10: `ack` while `irq` is low, and `reti` while the mask is empty, leave the in-service state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src | input | 20 | Request sources, two per slot |
| lvl_sel | input | 10 | Level select per slot |
| ack | input | 1 | CPU takes the presented vector |
| reti | input | 1 | CPU leaves the current handler |
| irq | output | 1 | Interrupt request to the CPU |
| vec_addr | output | 8 | Entry address of the winner |

## Verification
A table walks single sources and then the second source of the same slot, which separates the two OR inputs. It then applies pairs at mixed levels, which shows whether level outranks index, and pairs at equal levels, which shows that the tie-break picks the lower address. It also tries capped slots with the select bit set, which must stop at the middle level, and an all-request pattern. A directed sequence nests low, middle and top handlers, unwinds them with returns, and checks which held-back request reappears at each return. It also shows that stray strobes leave the mask untouched.

// File: rtl/prio_vec_arb.sv
module prio_vec_arb #(
  parameter int NVEC    = 10,
  parameter int NTOP    = 2,
  parameter int SRC_PER = 2,
  parameter int AW      = 8,
  parameter int BASE    = 3,
  parameter int STEP    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NVEC*SRC_PER-1:0]   src,
  input  logic [NVEC-1:0]           lvl_sel,
  input  logic                      ack,
  input  logic                      reti,
  output logic                      irq,
  output logic [AW-1:0]             vec_addr
);
  localparam int VW = (NVEC > 1) ? $clog2(NVEC) : 1;

  logic [NVEC-1:0] vreq;
  logic [1:0]      vlvl [NVEC];
  logic [2:0]      svc_q, svc_d, popped;
  logic [1:0]      cur_d, best_lvl, lvl_q;
  logic [VW-1:0]   best_idx, idx_q;
  logic            irq_q;

  for (genvar v = 0; v < NVEC; v++) begin : g_slot
    assign vreq[v] = |src[v*SRC_PER +: SRC_PER];
    if (v < NTOP) begin : g_top
      assign vlvl[v] = !vreq[v] ? 2'd0 : (lvl_sel[v] ? 2'd3 : 2'd1);
    end else begin : g_mid
      assign vlvl[v] = !vreq[v] ? 2'd0 : (lvl_sel[v] ? 2'd2 : 2'd1);
    end
  end

  always_comb begin
    popped = svc_q;
    if (reti) begin
      if (svc_q[2])      popped[2] = 1'b0;
      else if (svc_q[1]) popped[1] = 1'b0;
      else               popped[0] = 1'b0;
    end
    svc_d = popped;
    if (ack && irq_q && lvl_q != 2'd0) svc_d[lvl_q - 2'd1] = 1'b1;
  end

  assign cur_d = svc_d[2] ? 2'd3 : svc_d[1] ? 2'd2 : svc_d[0] ? 2'd1 : 2'd0;

  always_comb begin
    best_lvl = 2'd0;
    best_idx = '0;
    for (int v = NVEC - 1; v >= 0; v--) begin
      if (vlvl[v] != 2'd0 && vlvl[v] >= best_lvl) begin
        best_lvl = vlvl[v];
        best_idx = VW'(v);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_q <= '0;
      irq_q <= 1'b0;
      idx_q <= '0;
      lvl_q <= '0;
    end else begin
      svc_q <= svc_d;
      irq_q <= best_lvl > cur_d;
      idx_q <= best_idx;
      lvl_q <= best_lvl;
    end
  end

  assign irq      = irq_q;
  assign vec_addr = irq_q ? AW'(BASE + STEP * int'(idx_q)) : '0;
endmodule

// File: rtl/prio_vec_arb_chk.sv
module prio_vec_arb_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic          reti,
  input logic          irq,
  input logic [AW-1:0] vec_addr,
  input logic [2:0]    svc
);
  // R1
  addr_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (vec_addr[2:0] == 3'b011));
  // R1
  idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (vec_addr == '0));
  // R7
  push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && !reti) |=> ($countones(svc) == $past($countones(svc)) + 1));
  // R8
  pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack && svc != 3'b000) |=> ($countones(svc) + 1 == $past($countones(svc))));
  // R10
  stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq && !reti) |=> $stable(svc));
  // R10
  stray_reti_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack && svc == 3'b000) |=> $stable(svc));
endmodule

bind prio_vec_arb prio_vec_arb_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ack(ack), .reti(reti),
  .irq(irq), .vec_addr(vec_addr), .svc(svc_q)
);

// File: tb/prio_vec_arb_tb_top.sv
module prio_vec_arb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NROW = 10;
  // {src[19:0], lvl_sel[9:0], irq, vec_addr[7:0]}
  localparam logic [38:0] TBL [NROW] = '{
    {20'h00000, 10'h000, 1'b0, 8'h00},
    {20'h00010, 10'h000, 1'b1, 8'h13},
    {20'h00020, 10'h000, 1'b1, 8'h13},
    {20'h40040, 10'h000, 1'b1, 8'h1B},
    {20'h40040, 10'h200, 1'b1, 8'h4B},
    {20'h40004, 10'h202, 1'b1, 8'h0B},
    {20'h40004, 10'h200, 1'b1, 8'h4B},
    {20'h00009, 10'h003, 1'b1, 8'h03},
    {20'hFFFFF, 10'h000, 1'b1, 8'h03},
    {20'h10200, 10'h110, 1'b1, 8'h23}
  };
  localparam string TREQ [NROW] = '{"R1", "R2", "R2", "R5", "R4", "R3",
                                    "R3", "R5", "R5", "R5"};

  logic clk = 1'b0, rst_n = 1'b0, ack = 1'b0, reti = 1'b0, irq;
  logic [19:0] src = '0;
  logic [9:0]  lvl_sel = '0;
  logic [7:0]  vec_addr;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  prio_vec_arb dut_i (.clk(clk), .rst_n(rst_n), .src(src), .lvl_sel(lvl_sel),
                      .ack(ack), .reti(reti), .irq(irq), .vec_addr(vec_addr));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic expect_out(input string req, input logic ei, input logic [7:0] ea);
    n_chk++;
    if (irq !== ei || vec_addr !== ea) begin
      n_bad++;
      $display("FAIL %s: irq=%b addr=%h expected irq=%b addr=%h", req, irq, vec_addr, ei, ea);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse_ack;
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic pulse_reti;
    reti = 1'b1; tick(); reti = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    expect_out("R1", 1'b0, 8'h00);
    rst_n = 1'b1;
    tick();
    expect_out("R1", 1'b0, 8'h00);

    for (int i = 0; i < NROW; i++) begin
      src = TBL[i][38:19];
      lvl_sel = TBL[i][18:9];
      tick();
      expect_out(TREQ[i], TBL[i][8], TBL[i][7:0]);
    end

    // R6: output changes only at the edge
    src = '0; lvl_sel = '0; tick();
    src = 20'h00400;
    #1 expect_out("R6", 1'b0, 8'h00);
    tick();
    expect_out("R6", 1'b1, 8'h2B);

    // R7: low handler blocks its own level
    pulse_ack();
    expect_out("R7", 1'b0, 8'h00);
    src[12] = 1'b1; lvl_sel[6] = 1'b1; tick();
    expect_out("R7", 1'b1, 8'h33);
    pulse_ack();
    expect_out("R7", 1'b0, 8'h00);
    src[0] = 1'b1; lvl_sel[0] = 1'b1; tick();
    expect_out("R7", 1'b1, 8'h03);
    pulse_ack();
    expect_out("R7", 1'b0, 8'h00);
    // R9: top request still high reappears after return
    pulse_reti();
    expect_out("R9", 1'b1, 8'h03);
    pulse_ack();
    src[0] = 1'b0; tick();
    expect_out("R7", 1'b0, 8'h00);
    pulse_reti();
    expect_out("R8", 1'b0, 8'h00);
    // R8: popping middle exposes held-back middle request
    pulse_reti();
    expect_out("R8", 1'b1, 8'h33);
    src[12] = 1'b0; tick();
    expect_out("R7", 1'b0, 8'h00);
    pulse_reti();
    expect_out("R8", 1'b1, 8'h2B);

    // R10: stray strobes
    src = '0; lvl_sel = '0; tick();
    expect_out("R10", 1'b0, 8'h00);
    pulse_reti();
    pulse_ack();
    src[10] = 1'b1; tick();
    expect_out("R10", 1'b1, 8'h2B);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule